// File: doc/BRIEF.md
# Accumulator Computer I/O and Interrupt Unit

This block holds the character I/O and interrupt logic of a small accumulator computer. It has one 8-bit character register for input and one for output, each with a ready flag. On the accumulator side both registers move a whole character at once. On the device side each has a simple handshake: the device either loads a new input character or reports that an output operation has finished. The block decodes the register-reference I/O instructions that an external sequencer presents to it. It returns control strobes to the datapath: accumulator load, program counter load, skip request and sequence-counter clear.

The block also keeps an interrupt-enable flip-flop and an interrupt-request flip-flop. A request is raised when interrupts are enabled and either ready flag is set, but only between fetches. While the request is set, the block turns the next three timing steps into an interrupt cycle:
- It captures the program counter.
- It writes the captured value to memory word 0 and loads the program counter with 0.
- It increments the program counter to 1, disables interrupts and drops the request.

Top module: `io_intr_unit`

## Requirements
- R1: After reset, `fgi`, `fgo`, `ien` and `intr_req` are all 0, and none of `ac_wr_en`, `pc_wr_en`, `mem_we`, `skip`, `out_strobe` or `sc_clr` is asserted while the inputs are idle.
- R2: `dev_in_load` copies `dev_in_char` into the input register and sets `fgi` at the next edge. `dev_out_done` sets `fgo` at the next edge. A device event beats an instruction that clears the same flag in the same cycle.
- R3: An I/O instruction executes only when `d7`=1, `ir_ind`=1, `step`=3 and `intr_req`=0. It asserts `sc_clr` in that cycle. In any other case the function bits cause no action.
- R4: Function bit `ir_ctl[5]` (input): `ac_wr_en`=1 with `ac_wr_data` equal to the input register, and `fgi` is cleared at the edge.
- R5: Function bit `ir_ctl[4]` (output): `out_strobe`=1 in that cycle. At the edge `out_char` takes `ac_lo` and `fgo` is cleared.
- R6: Function bit `ir_ctl[3]` gives `skip` = `fgi`. Function bit `ir_ctl[2]` gives `skip` = `fgo`.
- R7: Function bit `ir_ctl[1]` sets `ien` and `ir_ctl[0]` clears it. If both are set, clearing wins.
- R8: `intr_req` rises at an edge where `ien`=1, `fgi` or `fgo` is 1, `step`>=3 and `intr_req`=0.
- R9: With `intr_req`=1, step 0 captures `pc_in`. Step 1 asserts `mem_we` with `mem_addr`=0 and `mem_wdata` equal to the captured value, plus `pc_wr_en` with `pc_wr_data`=0.
- R10: With `intr_req`=1, step 2 asserts `pc_wr_en` with `pc_wr_data` = `pc_in`+1 (modulo 2^12) and asserts `sc_clr`. At the edge both `ien` and `intr_req` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d7 | input | 1 | Opcode decode line for register-reference class |
| ir_ind | input | 1 | Indirect bit of the instruction |
| ir_ctl | input | 6 | Instruction function bits, [5] is the highest |
| step | input | 4 | Current timing step from the sequencer |
| ac_lo | input | 8 | Low character of the accumulator |
| pc_in | input | 12 | Current program counter |
| dev_in_load | input | 1 | Input device presents a new character |
| dev_in_char | input | 8 | Character from the input device |
| dev_out_done | input | 1 | Output device finished / is ready |
| ac_wr_en | output | 1 | Load accumulator low character |
| ac_wr_data | output | 8 | Character for the accumulator |
| out_char | output | 8 | Output register contents |
| out_strobe | output | 1 | Output register being loaded this cycle |
| skip | output | 1 | Skip the next instruction |
| pc_wr_en | output | 1 | Load program counter |
| pc_wr_data | output | 12 | Value for the program counter |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 12 | Memory write data |
| sc_clr | output | 1 | Clear the sequence counter |
| fgi | output | 1 | Input ready flag |
| fgo | output | 1 | Output ready flag |
| ien | output | 1 | Interrupt enable |
| intr_req | output | 1 | Interrupt request / cycle pending |

## Verification
Random cycles mix every decode qualifier: `d7`, the indirect bit, steps 0 to 5 and multi-bit function fields. This separates real I/O execution from instructions that must be ignored, and it exposes wrong priority between set and clear at the flags. Device loads and completions arrive at random times, so flag timing and the device-over-instruction priority are tried against skips and interrupt raising. A directed interrupt run starts from a known program counter and follows save, jump and exit step by step. A wrap case at the top program-counter value checks the increment modulo 2^12.

// File: rtl/io_intr_pkg.sv
`timescale 1ns/1ps
package io_intr_pkg;
  // positions within the 6-bit function field; decode depends on them
  localparam int FN_INP = 5;
  localparam int FN_OUT = 4;
  localparam int FN_SKI = 3;
  localparam int FN_SKO = 2;
  localparam int FN_ION = 1;
  localparam int FN_IOF = 0;
  localparam int FN_W   = 6;

  typedef struct packed {
    logic inp;
    logic outp;
    logic ski;
    logic sko;
    logic ion;
    logic iof;
  } io_fn_t;

  // increment modulo 2^w
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction
endpackage

// File: rtl/io_instr_decode.sv
`timescale 1ns/1ps
module io_instr_decode
  import io_intr_pkg::*;
#(
  parameter int STEP_W    = 4,
  parameter int EXEC_STEP = 3
) (
  input  logic              d7,
  input  logic              ir_ind,
  input  logic [FN_W-1:0]   ir_ctl,
  input  logic [STEP_W-1:0] step,
  input  logic              intr_busy,
  output logic              io_exec,
  output io_fn_t            fn
);
  localparam logic [STEP_W-1:0] EXEC_S = STEP_W'(EXEC_STEP);

  assign io_exec = d7 && ir_ind && (step == EXEC_S) && !intr_busy;

  always_comb begin
    fn      = '0;
    if (io_exec) begin
      fn.inp  = ir_ctl[FN_INP];
      fn.outp = ir_ctl[FN_OUT];
      fn.ski  = ir_ctl[FN_SKI];
      fn.sko  = ir_ctl[FN_SKO];
      fn.ion  = ir_ctl[FN_ION];
      fn.iof  = ir_ctl[FN_IOF];
    end
  end
endmodule

// File: rtl/io_port_regs.sv
`timescale 1ns/1ps
module io_port_regs #(
  parameter int CHR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_in_load,
  input  logic [CHR_W-1:0] dev_in_char,
  input  logic             dev_out_done,
  input  logic             take_in,
  input  logic             put_out,
  input  logic [CHR_W-1:0] ac_lo,
  output logic [CHR_W-1:0] in_reg,
  output logic [CHR_W-1:0] out_reg,
  output logic             fgi,
  output logic             fgo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg  <= '0;
      out_reg <= '0;
      fgi     <= 1'b0;
      fgo     <= 1'b0;
    end else begin
      if (dev_in_load) begin
        in_reg <= dev_in_char;
        fgi    <= 1'b1;
      end else if (take_in) begin
        fgi    <= 1'b0;
      end
      if (put_out) out_reg <= ac_lo;
      if (dev_out_done)  fgo <= 1'b1;
      else if (put_out)  fgo <= 1'b0;
    end
  end

  // R2
  fgi_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fgi) |-> $past(dev_in_load));
  // R4
  inp_clears_fgi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_in && !dev_in_load) |=> !fgi);
  // R5
  out_clears_fgo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_out && !dev_out_done) |=> (!fgo && out_reg == $past(ac_lo)));
endmodule

// File: rtl/intr_ctrl.sv
`timescale 1ns/1ps
module intr_ctrl
  import io_intr_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int STEP_W    = 4,
  parameter int FETCH_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              fgi,
  input  logic              fgo,
  input  logic              set_en,
  input  logic              clr_en,
  output logic              ien,
  output logic              intr_req,
  output logic [PC_W-1:0]   saved_pc,
  output logic              mem_we,
  output logic              pc_wr_en,
  output logic [PC_W-1:0]   pc_wr_data,
  output logic              seq_done
);
  localparam logic [STEP_W-1:0] S0    = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1    = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2    = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_MIN = STEP_W'(FETCH_LEN);

  logic capture, jump, raise;

  assign capture  = intr_req && (step == S0);
  assign jump     = intr_req && (step == S1);
  assign seq_done = intr_req && (step == S2);
  assign raise    = !intr_req && ien && (fgi || fgo) && (step >= S_MIN);

  assign mem_we     = jump;
  assign pc_wr_en   = jump || seq_done;
  assign pc_wr_data = jump ? '0 : PC_W'(wrap_inc(32'(pc_in), PC_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien      <= 1'b0;
      intr_req <= 1'b0;
      saved_pc <= '0;
    end else begin
      if (capture) saved_pc <= pc_in;
      if (seq_done) begin
        ien      <= 1'b0;
        intr_req <= 1'b0;
      end else begin
        if (clr_en)      ien <= 1'b0;
        else if (set_en) ien <= 1'b1;
        if (raise) intr_req <= 1'b1;
      end
    end
  end

  // R8
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_req) |-> ($past(ien) && ($past(fgi) || $past(fgo))));
  // R10
  intr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!ien && !intr_req));
  // R9
  save_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (saved_pc == $past(pc_in)));
endmodule

// File: rtl/io_intr_unit.sv
`timescale 1ns/1ps
module io_intr_unit
  import io_intr_pkg::*;
#(
  parameter int CHR_W     = 8,
  parameter int PC_W      = 12,
  parameter int STEP_W    = 4,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d7,
  input  logic              ir_ind,
  input  logic [5:0]        ir_ctl,
  input  logic [STEP_W-1:0] step,
  input  logic [CHR_W-1:0]  ac_lo,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              dev_in_load,
  input  logic [CHR_W-1:0]  dev_in_char,
  input  logic              dev_out_done,
  output logic              ac_wr_en,
  output logic [CHR_W-1:0]  ac_wr_data,
  output logic [CHR_W-1:0]  out_char,
  output logic              out_strobe,
  output logic              skip,
  output logic              pc_wr_en,
  output logic [PC_W-1:0]   pc_wr_data,
  output logic              mem_we,
  output logic [PC_W-1:0]   mem_addr,
  output logic [PC_W-1:0]   mem_wdata,
  output logic              sc_clr,
  output logic              fgi,
  output logic              fgo,
  output logic              ien,
  output logic              intr_req
);
  logic   io_exec, seq_done;
  io_fn_t fn;

  io_instr_decode #(.STEP_W(STEP_W), .EXEC_STEP(3)) u_dec (
    .d7(d7), .ir_ind(ir_ind), .ir_ctl(ir_ctl), .step(step),
    .intr_busy(intr_req), .io_exec(io_exec), .fn(fn)
  );

  io_port_regs #(.CHR_W(CHR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .dev_in_load(dev_in_load), .dev_in_char(dev_in_char),
    .dev_out_done(dev_out_done),
    .take_in(fn.inp), .put_out(fn.outp), .ac_lo(ac_lo),
    .in_reg(ac_wr_data), .out_reg(out_char), .fgi(fgi), .fgo(fgo)
  );

  intr_ctrl #(.PC_W(PC_W), .STEP_W(STEP_W), .FETCH_LEN(3)) u_intr (
    .clk(clk), .rst_n(rst_n), .step(step), .pc_in(pc_in),
    .fgi(fgi), .fgo(fgo), .set_en(fn.ion), .clr_en(fn.iof),
    .ien(ien), .intr_req(intr_req), .saved_pc(mem_wdata),
    .mem_we(mem_we), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .seq_done(seq_done)
  );

  assign ac_wr_en   = fn.inp;
  assign out_strobe = fn.outp;
  assign skip       = (fn.ski && fgi) || (fn.sko && fgo);
  assign sc_clr     = io_exec || seq_done;
  assign mem_addr   = PC_W'(SAVE_ADDR);

  // R3
  io_idle_in_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_req |-> !(ac_wr_en || out_strobe || skip));
  // R9
  mem_pc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (pc_wr_en && pc_wr_data == '0));
endmodule

// File: tb/tb_io_intr_unit.sv
`timescale 1ns/1ps
module tb_io_intr_unit;
  localparam int CHR_W = 8, PC_W = 12, STEP_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic d7 = 0, ir_ind = 0, dev_in_load = 0, dev_out_done = 0;
  logic [5:0] ir_ctl = '0;
  logic [STEP_W-1:0] step = '0;
  logic [CHR_W-1:0] ac_lo = '0, dev_in_char = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic ac_wr_en, out_strobe, skip, pc_wr_en, mem_we, sc_clr, fgi, fgo, ien, intr_req;
  logic [CHR_W-1:0] ac_wr_data, out_char;
  logic [PC_W-1:0] pc_wr_data, mem_addr, mem_wdata;

  int checks = 0, bad = 0;
  bit finished = 0;

  io_intr_unit dut (.*);

  always #2.5 clk = ~clk;

  // bench model state
  logic [CHR_W-1:0] m_in, m_out;
  logic m_fgi, m_fgo, m_ien, m_r;
  logic [PC_W-1:0] m_tr;

  function automatic logic [PC_W-1:0] next_pc(input logic [PC_W-1:0] p);
    return (p == {PC_W{1'b1}}) ? '0 : p + 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive_idle();
    d7 = 0; ir_ind = 0; ir_ctl = '0; step = 4'd5;
    dev_in_load = 0; dev_out_done = 0;
  endtask

  // inputs are set at negedge; check combinational outputs, then edge, then state
  task automatic run_cycle();
    logic ex, i0, i1, i2;
    logic [5:0] f;
    logic n_fgi, n_fgo, n_ien, n_r;
    logic [CHR_W-1:0] n_in, n_out;
    logic [PC_W-1:0] n_tr;
    #1;
    ex = d7 && ir_ind && step == 4'd3 && !m_r;
    f  = ex ? ir_ctl : 6'b0;
    i0 = m_r && step == 4'd0;
    i1 = m_r && step == 4'd1;
    i2 = m_r && step == 4'd2;
    chk("R4 ac_wr_en", ac_wr_en, f[5]);
    if (f[5]) chk("R4 ac_wr_data", ac_wr_data, m_in);
    chk("R5 out_strobe", out_strobe, f[4]);
    chk("R6 skip", skip, (f[3] && m_fgi) || (f[2] && m_fgo));
    chk("R3 sc_clr", sc_clr, ex || i2);
    chk("R9 mem_we", mem_we, i1);
    if (i1) begin
      chk("R9 mem_addr", mem_addr, 0);
      chk("R9 mem_wdata", mem_wdata, m_tr);
    end
    chk("R9 pc_wr_en", pc_wr_en, i1 || i2);
    if (i1) chk("R9 pc_wr_data", pc_wr_data, 0);
    if (i2) chk("R10 pc_wr_data", pc_wr_data, next_pc(pc_in));
    n_in  = dev_in_load ? dev_in_char : m_in;
    n_fgi = dev_in_load ? 1'b1 : (f[5] ? 1'b0 : m_fgi);
    n_out = f[4] ? ac_lo : m_out;
    n_fgo = dev_out_done ? 1'b1 : (f[4] ? 1'b0 : m_fgo);
    n_ien = i2 ? 1'b0 : (f[0] ? 1'b0 : (f[1] ? 1'b1 : m_ien));
    n_r   = i2 ? 1'b0 : ((!m_r && m_ien && (m_fgi || m_fgo) && step >= 4'd3) ? 1'b1 : m_r);
    n_tr  = i0 ? pc_in : m_tr;
    @(posedge clk);
    #1;
    m_in = n_in; m_fgi = n_fgi; m_out = n_out; m_fgo = n_fgo;
    m_ien = n_ien; m_r = n_r; m_tr = n_tr;
    chk("R2 fgi", fgi, m_fgi);
    chk("R2 fgo", fgo, m_fgo);
    chk("R7 ien", ien, m_ien);
    chk("R8 intr_req", intr_req, m_r);
    chk("R5 out_char", out_char, m_out);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_in = 0; m_out = 0; m_fgi = 0; m_fgo = 0; m_ien = 0; m_r = 0; m_tr = 0;
    #1;
    // R1 reset state
    chk("R1 fgi", fgi, 0); chk("R1 fgo", fgo, 0);
    chk("R1 ien", ien, 0); chk("R1 intr_req", intr_req, 0);
    chk("R1 strobes", {ac_wr_en, pc_wr_en, mem_we, skip, out_strobe, sc_clr}, 0);
    @(negedge clk);

    // directed: device ready, enable, interrupt cycle from pc 256
    dev_out_done = 1; run_cycle(); drive_idle();
    d7 = 1; ir_ind = 1; step = 4'd3; ir_ctl = 6'b000010; pc_in = 12'd255;
    run_cycle(); drive_idle();                 // R7 ion
    step = 4'd4; run_cycle();                  // R8 raise
    chk("R8 raised", intr_req, 1);
    // I/O instruction while pending must be ignored (R3)
    d7 = 1; ir_ind = 1; step = 4'd3; ir_ctl = 6'b010000; ac_lo = 8'h5A;
    run_cycle(); drive_idle();
    pc_in = 12'd256; step = 4'd0; run_cycle();
    pc_in = 12'd256; step = 4'd1; run_cycle();
    pc_in = 12'd0;   step = 4'd2; run_cycle(); // R10 pc -> 1
    chk("R10 exit ien", ien, 0);
    // wrap case: pending again, exit with pc at top
    d7 = 1; ir_ind = 1; step = 4'd3; ir_ctl = 6'b000010; run_cycle(); drive_idle();
    step = 4'd3; run_cycle();
    step = 4'd0; pc_in = 12'hFFF; run_cycle();
    step = 4'd1; run_cycle();
    step = 4'd2; run_cycle();
    // R2 priority: device load with input instruction same cycle
    dev_in_load = 1; dev_in_char = 8'hC3; run_cycle(); drive_idle();
    d7 = 1; ir_ind = 1; step = 4'd3; ir_ctl = 6'b101000;
    dev_in_load = 1; dev_in_char = 8'h3C; run_cycle(); drive_idle();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      d7 = ($urandom % 4) != 0;
      ir_ind = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: ir_ctl = 6'($urandom);
        default: ir_ctl = 6'(1 << ($urandom % 6));
      endcase
      step = m_r ? 4'($urandom % 4) : 4'($urandom % 6);
      ac_lo = 8'($urandom);
      pc_in = 12'($urandom);
      dev_in_load = ($urandom % 8) == 0;
      dev_in_char = 8'($urandom);
      dev_out_done = ($urandom % 8) == 0;
      run_cycle();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule